// File: doc/BRIEF.md
# SHA-256 Message Padding Unit

This unit sits in front of a SHA-256 compression core and turns a byte stream into whole 512-bit blocks. Message bytes arrive one per handshake over a valid/ready pair. A last flag marks the transfer that ends the message. The unit collects the bytes into a 64-byte block buffer. At the end of the message it writes the padding: a 0x80 marker byte, then zero bytes, then the message length in bits as a 64-bit big-endian number in the last eight bytes.

When the message ends too close to the end of a block, the unit inserts one more block that holds only padding. This happens when the marker does not fit, or when the marker fits but the eight-byte length does not. Each block is held on the output with a valid flag until the consumer accepts it. A final flag marks the one block that carries the length. While a block is waiting on the output, or while a padding-only block is being produced, the input is not ready.

A transfer can carry no data byte. Such a transfer is used together with the last flag, for example to send an empty message. The running byte count is 61 bits wide, so the bit length is that count shifted left by three. The count returns to zero once the final block has been accepted.

Top module: `sha256_block_padder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Message byte k of a block appears in `out_block[511-8k -: 8]`, so the first byte is the most significant. When 64 bytes have been accepted and none of them was last, that block is emitted with `out_final` = 0.
- R3: While `out_valid` is 1, `in_ready` is 0. A block that is not accepted keeps `out_block` and `out_final` unchanged until `out_ready` is 1.
- R4: If the message leaves n ≤ 55 bytes in its last block, that block holds the n bytes, then 0x80 at byte n, then zeros up to byte 55, then the length. It is the only block left and has `out_final` = 1.
- R5: The length field in `out_block[63:0]` of the final block equals 8 × the total number of message bytes, as a big-endian value.
- R6: If the message leaves n in 56..63 bytes in its last block, that block holds the bytes, then 0x80 at byte n, then zeros, with `out_final` = 0. It is followed by a block of 56 zero bytes plus the length, with `out_final` = 1.
- R7: If the last byte fills the block exactly (n = 64), the full block is emitted with `out_final` = 0. It is followed by a block of 0x80, then 55 zero bytes, then the length, with `out_final` = 1.
- R8: A handshake with `in_void` = 1 and `in_last` = 1 at the start of a message gives a single block: 0x80, then 55 zero bytes, then a length of zero, with `out_final` = 1.
- R9: A block is valid in the cycle after the handshake that fills or closes it. An extra padding block is valid in the cycle after the previous block is accepted. `out_valid` falls in the cycle after the final block is accepted.
- R10: After the final block is accepted, the byte count restarts at zero, so the next message reports only its own length.
- R11: A handshake with `in_void` = 1 stores no byte and adds nothing to the length. Its `in_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer present |
| in_ready | output | 1 | Unit accepts an input transfer |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Transfer ends the message |
| in_void | input | 1 | Transfer carries no byte |
| out_valid | output | 1 | Output block present |
| out_ready | input | 1 | Consumer accepts the block |
| out_block | output | 512 | Block, first byte in bits 511:504 |
| out_final | output | 1 | Block carries the length trailer |

## Verification
Every block is registered at the same edge as the input handshake that fills or closes it, so the bench samples `out_valid` and `out_block` at the falling edge right after that handshake. A padding-only block is registered at the edge that accepts the block before it, and it is checked at the next falling edge while `out_ready` is still held high. The bench drives `out_ready` at falling edges, sometimes in a stall pattern. It counts a block as accepted only when `out_ready` was set before the rising edge. While the block is stalled, the bench compares each cycle's `out_block` against the copy taken when the block first appeared.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
  localparam int BYTE_W    = 8;
  localparam int BLK_BYTES = 64;
  localparam int LEN_BYTES = 8;
  localparam int BLK_W     = BLK_BYTES * BYTE_W;
  localparam int LEN_W     = LEN_BYTES * BYTE_W;
  localparam int CNT_W     = LEN_W - 3;
  localparam int IDX_W     = $clog2(BLK_BYTES) + 1;
  localparam int ROOM_MAX  = BLK_BYTES - LEN_BYTES;

  localparam logic [BYTE_W-1:0] MARK_BYTE = 8'h80;

  typedef logic [BLK_W-1:0] block_t;
  typedef logic [LEN_W-1:0] bitlen_t;
  typedef logic [CNT_W-1:0] bytecnt_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    TAIL_NONE = 2'd0,
    TAIL_MARK = 2'd1,
    TAIL_LEN  = 2'd2
  } tail_e;

  // Bit length for a byte count: times eight.
  function automatic bitlen_t bits_of_bytes(bytecnt_t n);
    return {n, 3'b000};
  endfunction

  // Keep the first n bytes of body, optionally put the marker at byte n,
  // zero everything else, and optionally overlay the length trailer.
  function automatic block_t compose(block_t body, idx_t n, logic put_mark,
                                     logic put_len, bitlen_t len);
    block_t r;
    r = '0;
    for (int i = 0; i < BLK_BYTES; i++) begin
      logic [BYTE_W-1:0] b;
      if (i < int'(n))                  b = body[BLK_W-1-BYTE_W*i -: BYTE_W];
      else if (put_mark && i == int'(n)) b = MARK_BYTE;
      else                               b = '0;
      r[BLK_W-1-BYTE_W*i -: BYTE_W] = b;
    end
    if (put_len) r[LEN_W-1:0] = len;
    return r;
  endfunction
endpackage

// File: rtl/sha_pad_lencnt.sv
module sha_pad_lencnt
  import sha_pad_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inc,
  input  logic    clr,
  output bitlen_t bit_len
);
  bytecnt_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  assign bit_len = bits_of_bytes(cnt_q);

  // R5: the length only moves when a byte is counted or the count is cleared
  assert_len_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(bit_len));
endmodule

// File: rtl/sha_pad_buf.sv
module sha_pad_buf
  import sha_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  idx_t              idx,
  input  logic [BYTE_W-1:0] din,
  output block_t            merged
);
  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    logic              hit;
    assign hit = we && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   lane_q <= '0;
      else if (hit) lane_q <= din;
    end
    // write-through so a block closed by this byte already contains it
    assign merged[BLK_W-1-BYTE_W*g -: BYTE_W] = hit ? din : lane_q;
  end

  // R2: writes stay inside the 64 byte lanes
  assert_lane_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (idx < IDX_W'(BLK_BYTES)));
endmodule

// File: rtl/sha_pad_ctrl.sv
module sha_pad_ctrl
  import sha_pad_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    in_last,
  input  logic    in_void,
  output logic    in_ready,
  input  logic    out_ready,
  input  block_t  merged,
  input  bitlen_t bit_len,
  output logic    buf_we,
  output idx_t    buf_idx,
  output logic    cnt_inc,
  output logic    cnt_clr,
  output logic    out_valid,
  output block_t  out_block,
  output logic    out_final
);
  localparam idx_t N_FULL  = IDX_W'(BLK_BYTES);
  localparam idx_t N_LAST  = IDX_W'(BLK_BYTES - 1);
  localparam idx_t N_SPLIT = IDX_W'(ROOM_MAX);

  logic   hold_q, final_q;
  tail_e  tail_q;
  idx_t   fill_q;
  block_t blk_q;

  // named events
  logic    ev_accept, ev_take, ev_close, ev_full, ev_fit, ev_spill, ev_exact, ev_out_hs;
  idx_t    n_now;
  bitlen_t len_now;

  assign in_ready  = !hold_q;
  assign ev_accept = in_valid && in_ready;
  assign ev_take   = ev_accept && !in_void;
  assign ev_close  = ev_accept && in_last;
  assign n_now     = fill_q + IDX_W'(ev_take);
  assign ev_full   = ev_take && !in_last && (fill_q == N_LAST);
  assign ev_exact  = ev_close && (n_now == N_FULL);
  assign ev_fit    = ev_close && (n_now < N_SPLIT);
  assign ev_spill  = ev_close && !ev_exact && !ev_fit;
  assign ev_out_hs = hold_q && out_ready;
  assign len_now   = bit_len + (ev_take ? LEN_W'(8) : '0);

  assign buf_we  = ev_take;
  assign buf_idx = fill_q;
  assign cnt_inc = ev_take;
  assign cnt_clr = ev_out_hs && final_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      final_q <= 1'b0;
      tail_q  <= TAIL_NONE;
      fill_q  <= '0;
      blk_q   <= '0;
    end else if (ev_accept) begin
      if (ev_close) begin
        fill_q <= '0;
        hold_q <= 1'b1;
        if (ev_exact) begin
          blk_q   <= merged;
          final_q <= 1'b0;
          tail_q  <= TAIL_MARK;
        end else if (ev_fit) begin
          blk_q   <= compose(merged, n_now, 1'b1, 1'b1, len_now);
          final_q <= 1'b1;
          tail_q  <= TAIL_NONE;
        end else begin
          blk_q   <= compose(merged, n_now, 1'b1, 1'b0, len_now);
          final_q <= 1'b0;
          tail_q  <= TAIL_LEN;
        end
      end else if (ev_full) begin
        fill_q  <= '0;
        hold_q  <= 1'b1;
        blk_q   <= merged;
        final_q <= 1'b0;
        tail_q  <= TAIL_NONE;
      end else begin
        fill_q <= n_now;
      end
    end else if (ev_out_hs) begin
      unique case (tail_q)
        TAIL_MARK: begin
          blk_q   <= compose('0, '0, 1'b1, 1'b1, bit_len);
          final_q <= 1'b1;
          tail_q  <= TAIL_NONE;
        end
        TAIL_LEN: begin
          blk_q   <= compose('0, '0, 1'b0, 1'b1, bit_len);
          final_q <= 1'b1;
          tail_q  <= TAIL_NONE;
        end
        default: begin
          hold_q  <= 1'b0;
          final_q <= 1'b0;
        end
      endcase
    end
  end

  assign out_valid = hold_q;
  assign out_block = blk_q;
  assign out_final = final_q;

  // R3: a stalled block does not change
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_final)));

  // R5: the trailer of the final block matches the counter
  assert_final_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_final) |-> (out_block[LEN_W-1:0] == bit_len));

  // R6: a spilling message first produces a non-final block
  assert_spill_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_spill |=> (out_valid && !out_final));

  // R7: an exactly full final block is followed by a marker-only final block
  assert_exact_then_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out_hs && tail_q == TAIL_MARK) |=>
      (out_valid && out_final && out_block[BLK_W-1 -: BYTE_W] == MARK_BYTE));

  // R10: the count restarts after the final block is taken
  assert_len_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_out_hs && out_final) |=> (bit_len == '0));
endmodule

// File: rtl/sha256_block_padder.sv
module sha256_block_padder
  import sha_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_void,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_block,
  output logic              out_final
);
  logic    buf_we, cnt_inc, cnt_clr;
  idx_t    buf_idx;
  block_t  merged;
  bitlen_t bit_len;

  sha_pad_buf u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (buf_we),
    .idx    (buf_idx),
    .din    (in_data),
    .merged (merged)
  );

  sha_pad_lencnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (cnt_inc),
    .clr     (cnt_clr),
    .bit_len (bit_len)
  );

  sha_pad_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_void   (in_void),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .merged    (merged),
    .bit_len   (bit_len),
    .buf_we    (buf_we),
    .buf_idx   (buf_idx),
    .cnt_inc   (cnt_inc),
    .cnt_clr   (cnt_clr),
    .out_valid (out_valid),
    .out_block (out_block),
    .out_final (out_final)
  );

  // R1: nothing is presented before the first input
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && in_ready));
endmodule

// File: tb/sha256_block_padder_tb_top.sv
`timescale 1ns/1ps
module sha256_block_padder_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_last = 1'b0, in_void = 1'b0, out_ready = 1'b0;
  logic [7:0]   in_data = '0;
  logic         in_ready, out_valid, out_final;
  logic [511:0] out_block;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sha256_block_padder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_void(in_void),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block),
    .out_final(out_final)
  );

  // {length in bytes, seed, terminate with a void transfer}
  localparam int NV = 12;
  localparam logic [24:0] VEC_TAB [0:NV-1] = '{
    {16'd0,   8'h00, 1'b1}, {16'd1,   8'h11, 1'b0}, {16'd3,   8'h22, 1'b1},
    {16'd55,  8'h33, 1'b0}, {16'd56,  8'h44, 1'b0}, {16'd57,  8'h55, 1'b1},
    {16'd63,  8'h66, 1'b0}, {16'd64,  8'h77, 1'b0}, {16'd65,  8'h88, 1'b1},
    {16'd119, 8'h99, 1'b0}, {16'd120, 8'hAA, 1'b0}, {16'd128, 8'hBB, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int blocks_for(int len);
    return ((len + 8) / 64) + 1;
  endfunction

  // Padded stream built byte by byte from the rules, independent of the RTL.
  function automatic logic [511:0] exp_block(int len, logic [7:0] seed, int b);
    logic [511:0] r;
    int total;
    logic [63:0] lbits;
    total = blocks_for(len) * 64;
    lbits = 64'(len) * 64'd8;
    for (int j = 0; j < 64; j++) begin
      int p;
      logic [7:0] v;
      p = b * 64 + j;
      if (p < len)             v = 8'(seed + 8'(p));
      else if (p == len)       v = 8'h80;
      else if (p >= total - 8) v = 8'(lbits >> (8 * (total - 1 - p)));
      else                     v = 8'h00;
      r[511 - 8*j -: 8] = v;
    end
    return r;
  endfunction

  function automatic string blk_tag(int len, int b);
    if ((b + 1) * 64 <= len) return "R2";
    if (len == 0)            return "R8";
    if (len % 64 == 0)       return "R7";
    if (len % 64 >= 56)      return "R6";
    return "R4";
  endfunction

  task automatic drive_msg(int len, logic [7:0] seed, bit void_end);
    int i = 0;
    bit done = 0;
    while (!done) begin
      bit hs;
      @(negedge clk);
      in_valid = 1'b1;
      if (i < len) begin
        in_void = 1'b0;
        in_data = 8'(seed + 8'(i));
        in_last = (i == len - 1) && !void_end;
      end else begin
        in_void = 1'b1;
        in_data = 8'hEE;   // R11: must be ignored
        in_last = 1'b1;
      end
      hs = in_ready;
      @(posedge clk);
      if (hs) begin
        if (in_last) done = 1;
        i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_void = 1'b0;
  endtask

  task automatic collect_msg(int len, logic [7:0] seed, bit void_end, bit stall, string extra);
    int nb = blocks_for(len);
    int b = 0;
    int cyc = 0;
    bit have = 0;
    logic [511:0] held = '0;
    string tg;
    while (b < nb) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        if (have) chk(out_block == held, "R3 stalled block changed", out_block, held);
        else begin
          held = out_block; have = 1;
          chk(!in_ready, "R3 in_ready while block held", 512'(in_ready), 512'd0);
        end
        out_ready = stall ? (cyc % 3 == 0) : 1'b1;
        if (out_ready) begin
          tg = blk_tag(len, b);
          if (void_end && len > 0 && b == nb - 1) tg = {tg, " R11"};
          tg = {tg, " R5 ", extra};
          chk(out_block == exp_block(len, seed, b), tg, out_block, exp_block(len, seed, b));
          chk(out_final == (b == nb - 1), {tg, " final flag"}, 512'(out_final),
              512'(b == nb - 1));
          b++; have = 0;
        end
      end else out_ready = 1'b0;
    end
  endtask

  task automatic run_msg(int len, logic [7:0] seed, bit void_end, bit stall, string extra);
    fork
      drive_msg(len, seed, void_end);
      collect_msg(len, seed, void_end, stall, extra);
    join
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] e;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", 512'(out_valid), 512'd0);
    chk(in_ready == 1'b1,  "R1 in_ready after reset",  512'(in_ready),  512'd1);

    // table walk: every padding case, stalled and free-running consumer
    for (int v = 0; v < NV; v++) begin
      run_msg(int'(VEC_TAB[v][24:9]), VEC_TAB[v][8:1], VEC_TAB[v][0], v % 2 == 1, "table");
    end

    // R9: one-byte message, block due the cycle after the handshake
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A; in_last = 1'b1; in_void = 1'b0; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    e = exp_block(1, 8'h5A, 0);
    chk(out_valid == 1'b1, "R9 block valid one cycle after close", 512'(out_valid), 512'd1);
    chk(out_block == e, "R4 one-byte block", out_block, e);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R9 idle after final accepted",
        512'({out_valid, in_ready}), 512'b01);
    out_ready = 1'b0;

    // R9 and R6: 60-byte message, extra block right after the first is taken
    drive_msg(60, 8'hC0, 1'b0);
    chk(out_valid && !out_final, "R6 first block of spill", 512'({out_valid, out_final}),
        512'b10);
    e = exp_block(60, 8'hC0, 0);
    chk(out_block == e, "R6 spill block body", out_block, e);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e = exp_block(60, 8'hC0, 1);
    chk(out_valid && out_final, "R9 trailer block next cycle", 512'({out_valid, out_final}),
        512'b11);
    chk(out_block[63:0] == 64'd480, "R5 length of 60 bytes", 512'(out_block[63:0]), 512'd480);
    chk(out_block == e, "R6 trailer block", out_block, e);
    @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R9 valid drops after final", 512'(out_valid), 512'd0);
    out_ready = 1'b0;

    // R10: a fresh short message reports only its own length
    run_msg(2, 8'hD0, 1'b0, 1'b0, "R10 count restarted");
    // R7 with stall, then R8 back to back
    run_msg(64, 8'h01, 1'b1, 1'b1, "R7 void after full block");
    run_msg(0, 8'h00, 1'b1, 1'b0, "R8 empty again");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule